// File: doc/BRIEF.md
# Operand effective address generator

This block computes the memory address of one operand for a 16-bit machine with eight general registers, of which register 7 is the program counter. A 6-bit specifier is presented with a start strobe: bits 5:3 give the addressing mode and bits 2:0 the register. The block reads the register through a read port, applies the auto-increment or auto-decrement the mode calls for, fetches an index word from the instruction stream when needed, and follows one level of indirection through a word-read memory port with request/acknowledge. The final address comes out with a one-cycle done pulse.

Every modification of registers 0 to 6 is recorded in a small recovery log. If the instruction later aborts, the surrounding core reads the log back and undoes the changes. The log is cleared by an instruction-start strobe. A word read at an odd address is never issued: the block raises a fault pulse instead of done and makes no further register writes. Register mode (mode 0) and the operand data access itself are handled elsewhere.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode 1 returns the register value as the address, writes no register, logs nothing, and raises done two cycles after the start cycle.
- R2: Mode 2 returns the old register value and then increments the register. The step is 1 for a byte operand on registers 0 to 5 and 2 otherwise, including byte operands on register 6 or 7.
- R3: Mode 4 decrements the register by the same size-dependent step as mode 2 and returns the new value.
- R4: Modes 3 and 5 step the register by 2 (up or down, as modes 2 and 4 do) whatever the operand size, then read a word at the resulting pointer. The word read is the final address.
- R5: Mode 6 reads a displacement word at the PC, writes PC+2 back to register 7, and returns register + displacement. When the register is 7, the advanced PC is used as the base.
- R6: Mode 7 forms the same sum as mode 6, then reads a word at that sum. The word read is the final address.
- R7: All register and address arithmetic wraps modulo 65536.
- R8: A word read that would go to an odd address is not requested. Instead a fault pulse is raised in place of done, and no register is written from then on. In particular, an odd PC in mode 6 or 7 leaves the PC unchanged.
- R9: Each auto-modification of registers 0 to 6 appends one log entry. Entry bits 2:0 hold the register number, bit 3 is 1 for a decrement, and bit 4 is 1 when the step was 1 (byte). Changes to register 7 are not logged. log_count gives the number of entries, and reading an index at or beyond the count returns zero.
- R10: insn_start empties the log and wins over an append in the same cycle. The log holds LOG_DEPTH entries. Further appends are dropped and the count saturates at LOG_DEPTH.
- R11: A start with mode 0, or a start while the block is busy, is ignored: no register write, no done and no fault.
- R12: mem_req stays high with a stable address until mem_ack. Any number of wait cycles is tolerated, and the read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start | input | 1 | Instruction-start strobe; empties the recovery log |
| op_start | input | 1 | Begin address calculation for op_spec |
| op_spec | input | 6 | Operand specifier: mode in 5:3, register in 2:0 |
| op_byte | input | 1 | 1 for a byte operand, 0 for a word operand |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse; eff_addr is valid |
| fault | output | 1 | One-cycle odd-address abort pulse |
| eff_addr | output | AW | Final operand address, held after done |
| reg_rd_sel | output | 3 | Register read select |
| reg_rd_data | input | AW | Register read data, same cycle |
| reg_wr_en | output | 1 | Register write enable |
| reg_wr_sel | output | 3 | Register write select |
| reg_wr_data | output | AW | Register write data |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Word read address |
| mem_ack | input | 1 | Read acknowledge; data valid |
| mem_rdata | input | AW | Read data |
| log_rd_idx | input | LOG_IW | Recovery log read index |
| log_rd_entry | output | 5 | Log entry at log_rd_idx |
| log_count | output | LOG_CW | Number of valid log entries |

## Verification
A wrong mode decode or a wrong step size shows up at the ports within two cycles of the start: a wrong register write, or a wrong eff_addr at the done pulse. The register file is observed after every operation, as is the log entry that should accompany each write. A sequencer that takes the wrong path through the displacement or indirect states shows up as a different number of memory requests, a wrong final address, or a done that arrives early or late. An error in the odd-address handling shows up in two ways: as a request with bit 0 set, or as a register change after the fault pulse. Both are watched on every cycle of those tests.

// File: rtl/opag_pkg.sv
package opag_pkg;

  localparam int RN_W = 3;

  localparam logic [2:0] AM_REG  = 3'd0;
  localparam logic [2:0] AM_DEF  = 3'd1;
  localparam logic [2:0] AM_INC  = 3'd2;
  localparam logic [2:0] AM_INCD = 3'd3;
  localparam logic [2:0] AM_DEC  = 3'd4;
  localparam logic [2:0] AM_DECD = 3'd5;
  localparam logic [2:0] AM_IDX  = 3'd6;
  localparam logic [2:0] AM_IDXD = 3'd7;

  localparam logic [RN_W-1:0] RN_SP = 3'd6;
  localparam logic [RN_W-1:0] RN_PC = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_DISP = 2'd2,
    ST_IND  = 2'd3
  } opag_state_e;

  // recovery record: bit4 = unit step, bit3 = decrement, bits2:0 = register
  typedef struct packed {
    logic            unit_step;
    logic            is_dec;
    logic [RN_W-1:0] rnum;
  } opag_rec_t;

endpackage

// File: rtl/opag_step_unit.sv
module opag_step_unit
  import opag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]      mode,
  input  logic [RN_W-1:0] rnum,
  input  logic            byte_op,
  input  logic [AW-1:0]   base,
  output logic [AW-1:0]   new_val,
  output logic [AW-1:0]   use_addr,
  output logic            is_dec,
  output logic            unit_step
);

  logic [AW-1:0] delta;
  logic          plain_mode;
  logic          wide_reg;

  always_comb begin
    plain_mode = (mode == AM_INC) || (mode == AM_DEC);
    wide_reg   = (rnum == RN_SP) || (rnum == RN_PC);
    unit_step  = byte_op && plain_mode && !wide_reg;
    is_dec     = (mode == AM_DEC) || (mode == AM_DECD);
    delta      = unit_step ? AW'(1) : AW'(2);
    new_val    = is_dec ? (base - delta) : (base + delta);
    use_addr   = is_dec ? new_val : base;
  end

endmodule

// File: rtl/opag_rec_log.sv
module opag_rec_log
  import opag_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  opag_rec_t     rec,
  input  logic [IW-1:0] rd_idx,
  output opag_rec_t     rd_entry,
  output logic [CW-1:0] count
);

  opag_rec_t     ent_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          room;

  always_comb begin
    room  = (cnt_q < CW'(DEPTH));
    cnt_n = cnt_q;
    if (clear)             cnt_n = '0;
    else if (push && room) cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !clear && (cnt_q == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ent_q[g] <= '0;
      else if (slot_we) ent_q[g] <= rec;
    end
  end

  always_comb begin
    if (CW'(rd_idx) < cnt_q) rd_entry = ent_q[rd_idx];
    else                     rd_entry = '0;
  end

  assign count = cnt_q;

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  a_r9_no_pc_record: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (rec.rnum != RN_PC));

endmodule

// File: rtl/opag_ctrl.sv
module opag_ctrl
  import opag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic [5:0]      op_spec,
  input  logic            op_byte,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [AW-1:0]   eff_addr,
  output logic [RN_W-1:0] reg_rd_sel,
  input  logic [AW-1:0]   reg_rd_data,
  output logic            reg_wr_en,
  output logic [RN_W-1:0] reg_wr_sel,
  output logic [AW-1:0]   reg_wr_data,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [AW-1:0]   mem_rdata,
  output logic [2:0]      cur_mode,
  output logic [RN_W-1:0] cur_rnum,
  output logic            cur_byte,
  input  logic [AW-1:0]   stp_new,
  input  logic [AW-1:0]   stp_addr,
  input  logic            stp_dec,
  input  logic            stp_unit,
  output logic            log_push,
  output opag_rec_t       log_rec
);

  opag_state_e     state_q, state_n;
  logic [2:0]      mode_q;
  logic [RN_W-1:0] rnum_q;
  logic            byte_q;
  logic [AW-1:0]   ptr_q, ptr_n;
  logic            ptr_en;
  logic [AW-1:0]   ea_q, ea_n;
  logic            ea_en;
  logic            done_q, done_n;
  logic            fault_q, fault_n;
  logic            spec_en;
  logic [AW-1:0]   pc_next;
  logic [AW-1:0]   idx_base;
  logic [AW-1:0]   idx_sum;

  assign cur_mode = mode_q;
  assign cur_rnum = rnum_q;
  assign cur_byte = byte_q;
  assign pc_next  = ptr_q + AW'(2);
  assign idx_base = (rnum_q == RN_PC) ? pc_next : reg_rd_data;
  assign idx_sum  = idx_base + mem_rdata;

  always_comb begin
    state_n     = state_q;
    ptr_n       = ptr_q;
    ptr_en      = 1'b0;
    ea_n        = ea_q;
    ea_en       = 1'b0;
    done_n      = 1'b0;
    fault_n     = 1'b0;
    spec_en     = 1'b0;
    reg_rd_sel  = rnum_q;
    reg_wr_en   = 1'b0;
    reg_wr_sel  = rnum_q;
    reg_wr_data = stp_new;
    mem_req     = 1'b0;
    log_push    = 1'b0;
    log_rec     = '{unit_step: stp_unit, is_dec: stp_dec, rnum: rnum_q};

    unique case (state_q)
      ST_IDLE: begin
        if (op_start && (op_spec[5:3] != AM_REG)) begin
          spec_en = 1'b1;
          state_n = ST_EVAL;
        end
      end

      ST_EVAL: begin
        unique case (mode_q)
          AM_DEF: begin
            ea_n    = reg_rd_data;
            ea_en   = 1'b1;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end
          AM_INC, AM_DEC, AM_INCD, AM_DECD: begin
            reg_wr_en = 1'b1;
            log_push  = (rnum_q != RN_PC);
            if ((mode_q == AM_INC) || (mode_q == AM_DEC)) begin
              ea_n    = stp_addr;
              ea_en   = 1'b1;
              done_n  = 1'b1;
              state_n = ST_IDLE;
            end else begin
              ptr_n   = stp_addr;
              ptr_en  = 1'b1;
              state_n = ST_IND;
            end
          end
          AM_IDX, AM_IDXD: begin
            reg_rd_sel = RN_PC;
            ptr_n      = reg_rd_data;
            ptr_en     = 1'b1;
            state_n    = ST_DISP;
          end
          default: state_n = ST_IDLE;
        endcase
      end

      ST_DISP: begin
        if (ptr_q[0]) begin
          fault_n = 1'b1;
          state_n = ST_IDLE;
        end else begin
          mem_req = 1'b1;
          if (mem_ack) begin
            reg_wr_en   = 1'b1;
            reg_wr_sel  = RN_PC;
            reg_wr_data = pc_next;
            if (mode_q == AM_IDX) begin
              ea_n    = idx_sum;
              ea_en   = 1'b1;
              done_n  = 1'b1;
              state_n = ST_IDLE;
            end else begin
              ptr_n   = idx_sum;
              ptr_en  = 1'b1;
              state_n = ST_IND;
            end
          end
        end
      end

      ST_IND: begin
        if (ptr_q[0]) begin
          fault_n = 1'b1;
          state_n = ST_IDLE;
        end else begin
          mem_req = 1'b1;
          if (mem_ack) begin
            ea_n    = mem_rdata;
            ea_en   = 1'b1;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end

      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      fault_q <= fault_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_REG;
      rnum_q <= '0;
      byte_q <= 1'b0;
    end else if (spec_en) begin
      mode_q <= op_spec[5:3];
      rnum_q <= op_spec[2:0];
      byte_q <= op_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ea_q <= '0;
    else if (ea_en) ea_q <= ea_n;
  end

  assign mem_addr = ptr_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign fault    = fault_q;
  assign eff_addr = ea_q;

  a_r8_no_odd_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r8_quiet_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (!busy && !reg_wr_en && !mem_req));

  a_r11_report_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || fault_q) |-> !busy);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, fault_q}));

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opag_pkg::*;
#(
  parameter  int AW        = 16,
  parameter  int LOG_DEPTH = 4,
  localparam int LOG_IW    = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int LOG_CW    = $clog2(LOG_DEPTH + 1),
  localparam int REC_W     = $bits(opag_rec_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_start,
  input  logic              op_start,
  input  logic [5:0]        op_spec,
  input  logic              op_byte,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [AW-1:0]     eff_addr,
  output logic [2:0]        reg_rd_sel,
  input  logic [AW-1:0]     reg_rd_data,
  output logic              reg_wr_en,
  output logic [2:0]        reg_wr_sel,
  output logic [AW-1:0]     reg_wr_data,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [AW-1:0]     mem_rdata,
  input  logic [LOG_IW-1:0] log_rd_idx,
  output logic [REC_W-1:0]  log_rd_entry,
  output logic [LOG_CW-1:0] log_count
);

  logic [2:0]      cur_mode;
  logic [RN_W-1:0] cur_rnum;
  logic            cur_byte;
  logic [AW-1:0]   stp_new;
  logic [AW-1:0]   stp_addr;
  logic            stp_dec;
  logic            stp_unit;
  logic            log_push;
  opag_rec_t       log_rec;
  opag_rec_t       log_out;

  opag_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_start    (op_start),
    .op_spec     (op_spec),
    .op_byte     (op_byte),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .eff_addr    (eff_addr),
    .reg_rd_sel  (reg_rd_sel),
    .reg_rd_data (reg_rd_data),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .cur_mode    (cur_mode),
    .cur_rnum    (cur_rnum),
    .cur_byte    (cur_byte),
    .stp_new     (stp_new),
    .stp_addr    (stp_addr),
    .stp_dec     (stp_dec),
    .stp_unit    (stp_unit),
    .log_push    (log_push),
    .log_rec     (log_rec)
  );

  opag_step_unit #(.AW(AW)) u_step (
    .mode      (cur_mode),
    .rnum      (cur_rnum),
    .byte_op   (cur_byte),
    .base      (reg_rd_data),
    .new_val   (stp_new),
    .use_addr  (stp_addr),
    .is_dec    (stp_dec),
    .unit_step (stp_unit)
  );

  opag_rec_log #(.DEPTH(LOG_DEPTH)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (insn_start),
    .push     (log_push),
    .rec      (log_rec),
    .rd_idx   (log_rd_idx),
    .rd_entry (log_out),
    .count    (log_count)
  );

  assign log_rd_entry = log_out;

endmodule

// File: tb/opnd_addr_gen_test.sv
`timescale 1ns/1ps
module opnd_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_start, op_start, op_byte;
  logic [5:0]  op_spec;
  logic        busy, done, fault;
  logic [15:0] eff_addr;
  logic [2:0]  reg_rd_sel, reg_wr_sel;
  logic [15:0] reg_rd_data, reg_wr_data;
  logic        reg_wr_en;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr, mem_rdata;
  logic [1:0]  log_rd_idx;
  logic [4:0]  log_rd_entry;
  logic [2:0]  log_count;

  logic [15:0] regs [8];
  logic [15:0] mem  [64];
  logic        tb_wr;
  logic [2:0]  tb_sel;
  logic [15:0] tb_dat;
  int          wait_n;
  int          wcnt;
  int          odd_req;
  int          nreq;
  int          checks = 0;
  int          fails  = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  opnd_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .op_start(op_start),
    .op_spec(op_spec), .op_byte(op_byte), .busy(busy), .done(done),
    .fault(fault), .eff_addr(eff_addr), .reg_rd_sel(reg_rd_sel),
    .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .log_rd_idx(log_rd_idx),
    .log_rd_entry(log_rd_entry), .log_count(log_count)
  );

  assign reg_rd_data = regs[reg_rd_sel];
  assign mem_rdata   = mem[mem_addr[6:1]];
  assign mem_ack     = mem_req && (wcnt >= wait_n);

  always @(posedge clk) begin
    if (tb_wr) regs[tb_sel] <= tb_dat;
    else if (reg_wr_en) regs[reg_wr_sel] <= reg_wr_data;
  end

  always @(posedge clk) begin
    wcnt <= (mem_req && !mem_ack) ? wcnt + 1 : 0;
    if (mem_req && mem_addr[0]) odd_req <= odd_req + 1;
    if (mem_req && mem_ack) nreq <= nreq + 1;
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_reg(input logic [2:0] r, input logic [15:0] v);
    @(negedge clk); tb_wr = 1'b1; tb_sel = r; tb_dat = v;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); insn_start = 1'b1;
    @(negedge clk); insn_start = 1'b0;
  endtask

  task automatic run_op(input logic [5:0] spec, input logic byt,
                        output logic gd, output logic gf, output int cyc);
    @(negedge clk); op_spec = spec; op_byte = byt; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
    cyc = 1; gd = 1'b0; gf = 1'b0;
    forever begin
      if (done || fault) begin gd = done; gf = fault; break; end
      if (cyc >= 40) break;
      @(negedge clk); cyc++;
    end
  endtask

  function automatic logic [15:0] entry(input int idx);
    return 16'(log_rd_entry);
  endfunction

  task automatic read_log(input int idx, output logic [15:0] e);
    log_rd_idx = 2'(idx); #0.5; e = entry(idx);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", 16'(busy), 16'h0);
    chk("R11 reset done", 16'(done), 16'h0);
    chk("R8 reset fault", 16'(fault), 16'h0);
    chk("R10 reset log_count", 16'(log_count), 16'h0);
  endtask

  task automatic t_mode1();
    logic gd, gf; int c;
    clear_log(); set_reg(3, 16'h1234);
    run_op(6'o13, 1'b0, gd, gf, c);
    chk("R1 done", 16'(gd), 16'h1);
    chk("R1 latency", 16'(c), 16'd2);
    chk("R1 address", eff_addr, 16'h1234);
    chk("R1 register kept", regs[3], 16'h1234);
    chk("R1 nothing logged", 16'(log_count), 16'h0);
  endtask

  task automatic t_mode2();
    logic gd, gf; int c; logic [15:0] e;
    clear_log(); set_reg(2, 16'h0100); set_reg(6, 16'h0200);
    run_op(6'o22, 1'b1, gd, gf, c);
    chk("R2 byte address", eff_addr, 16'h0100);
    chk("R2 byte step 1", regs[2], 16'h0101);
    run_op(6'o26, 1'b1, gd, gf, c);
    chk("R2 R6 byte steps 2", regs[6], 16'h0202);
    run_op(6'o22, 1'b0, gd, gf, c);
    chk("R2 word step 2", regs[2], 16'h0103);
    chk("R9 count", 16'(log_count), 16'd3);
    read_log(0, e); chk("R9 entry byte inc R2", e, 16'h0012);
    read_log(1, e); chk("R9 entry inc R6", e, 16'h0006);
    read_log(2, e); chk("R9 entry word inc R2", e, 16'h0002);
    read_log(3, e); chk("R9 beyond count zero", e, 16'h0000);
    clear_log(); set_reg(7, 16'h0060);
    run_op(6'o27, 1'b1, gd, gf, c);
    chk("R2 PC byte address", eff_addr, 16'h0060);
    chk("R2 PC byte steps 2", regs[7], 16'h0062);
    chk("R9 PC not logged", 16'(log_count), 16'h0);
  endtask

  task automatic t_mode4();
    logic gd, gf; int c; logic [15:0] e;
    clear_log(); set_reg(1, 16'h0000);
    run_op(6'o41, 1'b1, gd, gf, c);
    chk("R3 done", 16'(gd), 16'h1);
    chk("R7 wrap address", eff_addr, 16'hFFFF);
    chk("R3 byte decrement", regs[1], 16'hFFFF);
    read_log(0, e); chk("R9 entry byte dec R1", e, 16'h0019);
    set_reg(4, 16'h0010);
    run_op(6'o44, 1'b0, gd, gf, c);
    chk("R3 word address", eff_addr, 16'h000E);
    chk("R3 word decrement", regs[4], 16'h000E);
  endtask

  task automatic t_deferred();
    logic gd, gf; int c; logic [15:0] e;
    clear_log(); wait_n = 2;
    set_reg(4, 16'h0010); mem[8] = 16'h0ABC;
    run_op(6'o34, 1'b1, gd, gf, c);
    chk("R4 mode3 address", eff_addr, 16'h0ABC);
    chk("R4 mode3 byte steps 2", regs[4], 16'h0012);
    read_log(0, e); chk("R9 entry mode3", e, 16'h0004);
    set_reg(5, 16'h0022); mem[16] = 16'h7776;
    run_op(6'o55, 1'b1, gd, gf, c);
    chk("R4 mode5 address", eff_addr, 16'h7776);
    chk("R4 mode5 steps 2", regs[5], 16'h0020);
    read_log(1, e); chk("R9 entry mode5", e, 16'h000D);
    chk("R12 done after waits", 16'(gd), 16'h1);
    wait_n = 0;
  endtask

  task automatic t_index();
    logic gd, gf; int c; int n0;
    clear_log(); wait_n = 3;
    set_reg(7, 16'h0030); set_reg(2, 16'h1000); mem[24] = 16'h0005;
    n0 = nreq;
    run_op(6'o62, 1'b0, gd, gf, c);
    chk("R5 address", eff_addr, 16'h1005);
    chk("R5 PC advanced", regs[7], 16'h0032);
    chk("R12 one read", 16'(nreq - n0), 16'd1);
    chk("R9 PC change not logged", 16'(log_count), 16'h0);
    wait_n = 0;
    set_reg(7, 16'h0040); mem[32] = 16'hFFFE;
    run_op(6'o67, 1'b0, gd, gf, c);
    chk("R5 PC relative uses advanced PC", eff_addr, 16'h0040);
    chk("R5 latency", 16'(c), 16'd3);
    set_reg(7, 16'h0050); set_reg(0, 16'h0004);
    mem[40] = 16'h0010; mem[10] = 16'hBEEF;
    n0 = nreq;
    run_op(6'o70, 1'b0, gd, gf, c);
    chk("R6 address", eff_addr, 16'hBEEF);
    chk("R6 two reads", 16'(nreq - n0), 16'd2);
    chk("R6 PC advanced", regs[7], 16'h0052);
  endtask

  task automatic t_odd();
    logic gd, gf; int c; int o0;
    clear_log(); o0 = odd_req;
    set_reg(4, 16'h0011);
    run_op(6'o34, 1'b0, gd, gf, c);
    chk("R8 fault", 16'(gf), 16'h1);
    chk("R8 no done", 16'(gd), 16'h0);
    chk("R8 register stepped before read", regs[4], 16'h0013);
    chk("R9 stepped register logged", 16'(log_count), 16'h1);
    set_reg(7, 16'h0071);
    run_op(6'o61, 1'b0, gd, gf, c);
    chk("R8 odd PC fault", 16'(gf), 16'h1);
    repeat (3) @(negedge clk);
    chk("R8 PC unchanged", regs[7], 16'h0071);
    chk("R8 no odd request", 16'(odd_req - o0), 16'h0);
  endtask

  task automatic t_ignored();
    logic gd, gf; int c;
    clear_log(); set_reg(3, 16'h4444);
    run_op(6'o03, 1'b0, gd, gf, c);
    chk("R11 mode0 no done", 16'({gd, gf}), 16'h0);
    chk("R11 mode0 reg kept", regs[3], 16'h4444);
    set_reg(0, 16'h0100); set_reg(1, 16'h0200); wait_n = 4;
    set_reg(7, 16'h0030); mem[24] = 16'h0000;
    @(negedge clk); op_spec = 6'o61; op_byte = 1'b0; op_start = 1'b1;
    @(negedge clk); op_spec = 6'o20; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 start while busy ignored", regs[0], 16'h0100);
    chk("R11 busy op result", eff_addr, 16'h0200);
    wait_n = 0;
  endtask

  task automatic t_log_full();
    logic gd, gf; int c;
    clear_log(); set_reg(0, 16'h0000);
    for (int i = 0; i < 5; i++) run_op(6'o20, 1'b0, gd, gf, c);
    chk("R10 saturates", 16'(log_count), 16'd4);
    chk("R7 register after five steps", regs[0], 16'h000A);
    clear_log();
    chk("R10 cleared", 16'(log_count), 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_start = 1'b0; op_start = 1'b0; op_byte = 1'b0;
    op_spec = '0; tb_wr = 1'b0; tb_sel = '0; tb_dat = '0; log_rd_idx = '0;
    wait_n = 0; wcnt = 0; odd_req = 0; nreq = 0;
    for (int i = 0; i < 8; i++) regs[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode1();
    t_mode2();
    t_mode4();
    t_deferred();
    t_index();
    t_odd();
    t_ignored();
    t_log_full();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule